// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block erases a contiguous run of erase blocks in a raw NAND device. The block sits on a simple strobe port: a command strobe, an address strobe and a read strobe, with one byte driven out and one data word read back. A single start pulse hands it a first and a last block index together with the device geometry. The geometry is the total block count, whether pages are small or large, the number of address cycles the part expects, and the pages per block given as a power-of-two shift. The sequencer then walks the range one block at a time. For each block it sends the setup opcode, the row part of the page address, and the confirm opcode. It then polls the status register until the part reports ready, and reads the status once more to learn whether the erase held.

Every block that erases cleanly raises a one-cycle pass strobe carrying its index. A block whose status shows a failure raises a one-cycle fail strobe, and the walk carries on to the next block. A part that never becomes ready stops the whole run. The wait limit is counted in ticks of a programmable clock divider. The run ends with a one-cycle done pulse and a result code: completed, timed out, or range rejected.

Top module: `nand_erase_seq`

## Requirements
- R1: A start whose last block is not below the block count, or whose first block is above its last block, produces a done pulse in the following cycle with result 2 (range rejected), and no strobe on the NAND port.
- R2: The page number of block b is b shifted left by the pages-per-block shift input. The row bytes carry this page number.
- R3: For each block the port sees, in consecutive cycles, command 0x60, then the row bytes least significant byte first, then command 0xD0.
- R4: When large_page is 0, two row bytes are sent. A third byte (page[23:16]) is added when the address-cycle count is at least 4. A fourth byte (page[31:24]) is added when the count is at least 5.
- R5: When large_page is 1, two row bytes are sent, plus page[23:16] only when the address-cycle count is at least 5.
- R6: Readiness is polled by command 0x70 followed by a read strobe, with status bit 6 meaning ready. Once ready is seen, a further 0x70 and read fetch the status that decides the outcome.
- R7: When status bit 0 of the final read is 1, the block raises blk_bad with its index on blk_idx. Otherwise it raises blk_ok. Either way the sequencer goes on to the next block in the range.
- R8: The wait timer starts at zero when the confirm command is sent and advances one tick every tick_div+1 clock cycles while polling. A poll that finds the part not ready after TMO_LIMIT ticks have elapsed ends the run with result 1 (timeout), and no later block is started.
- R9: Status is taken from the low byte of the nd_io_in word. The upper bits have no effect.
- R10: After reset, and between runs, busy, done and every strobe are low. After the last block's outcome strobe, done pulses in the same cycle with result 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| first_blk | input | BLK_W | First block index |
| last_blk | input | BLK_W | Last block index, inclusive |
| blk_count | input | BLK_W+1 | Blocks in the device |
| large_page | input | 1 | 1 selects the large-page row format |
| addr_cycles | input | 3 | Address cycles the device expects |
| ppb_shift | input | SHIFT_W | log2 of pages per block |
| tick_div | input | DIV_W | Clock cycles per timer tick, minus one |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 completed, 1 timeout, 2 range rejected; valid with done |
| blk_ok | output | 1 | One-cycle pass strobe for blk_idx |
| blk_bad | output | 1 | One-cycle fail strobe for blk_idx |
| blk_idx | output | BLK_W | Index of the block just finished |
| nd_cmd_we | output | 1 | Command strobe |
| nd_addr_we | output | 1 | Address strobe |
| nd_rd | output | 1 | Data read strobe; nd_io_in sampled this cycle |
| nd_io | output | 8 | Command or address byte |
| nd_io_in | input | DATA_W | Data word from the device |

## Verification
The bench builds the sequencer with a 12-bit block index, a 4-bit shift and a 16-bit data word. These values let a block near 2048 with a shift of 15 drive all four row bytes and exercise the cycle-count rule on both page formats. TMO_LIMIT is reduced to 6 and the divider to 4 bits, so a part that never becomes ready expires after a handful of polls. At that size the bench can compare the exact number of status polls for divider settings 0 and 1. It can also place the ready reply on the last poll that still counts as in time.

// File: rtl/nes_pkg.sv
package nes_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_ROW, S_CONF, S_PCMD, S_PRD, S_SCMD, S_SRD
    } state_e;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_STATUS      = 8'h70;

    localparam int RDY_BIT  = 6;
    localparam int FAIL_BIT = 0;

    localparam logic [1:0] RES_OK      = 2'd0;
    localparam logic [1:0] RES_TIMEOUT = 2'd1;
    localparam logic [1:0] RES_RANGE   = 2'd2;
endpackage

// File: rtl/nes_row_fmt.sv
module nes_row_fmt #(
    parameter int PAGE_W = 32
) (
    input  logic              large_page,
    input  logic [2:0]        addr_cycles,
    input  logic [PAGE_W-1:0] page,
    input  logic [1:0]        sel,
    output logic [2:0]        nbytes,
    output logic [7:0]        row_byte
);
    localparam int PAD_W = 32;

    logic [PAD_W-1:0] page_pad;
    assign page_pad = PAD_W'(page);

    always_comb begin
        if (large_page) begin
            nbytes = (addr_cycles >= 3'd5) ? 3'd3 : 3'd2;
        end else if (addr_cycles >= 3'd5) begin
            nbytes = 3'd4;
        end else if (addr_cycles >= 3'd4) begin
            nbytes = 3'd3;
        end else begin
            nbytes = 3'd2;
        end
    end

    assign row_byte = page_pad[8*sel +: 8];
endmodule

// File: rtl/nes_wait_timer.sv
module nes_wait_timer #(
    parameter int DIV_W     = 16,
    parameter int TMO_LIMIT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             expired
);
    localparam int CNT_W = $clog2(TMO_LIMIT + 1);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clr) begin
            tmr_d = '0;
        end else if (run) begin
            if (tmr_q.pre == div) begin
                tmr_d.pre = '0;
                if (tmr_q.cnt != CNT_W'(TMO_LIMIT)) tmr_d.cnt = tmr_q.cnt + 1'b1;
            end else begin
                tmr_d.pre = tmr_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = (tmr_q.cnt == CNT_W'(TMO_LIMIT));
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq #(
    parameter int BLK_W     = 12,
    parameter int PAGE_W    = 32,
    parameter int SHIFT_W   = 4,
    parameter int DIV_W     = 16,
    parameter int DATA_W    = 16,
    parameter int TMO_LIMIT = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BLK_W-1:0]   first_blk,
    input  logic [BLK_W-1:0]   last_blk,
    input  logic [BLK_W:0]     blk_count,
    input  logic               large_page,
    input  logic [2:0]         addr_cycles,
    input  logic [SHIFT_W-1:0] ppb_shift,
    input  logic [DIV_W-1:0]   tick_div,
    output logic               busy,
    output logic               done,
    output logic [1:0]         result,
    output logic               blk_ok,
    output logic               blk_bad,
    output logic [BLK_W-1:0]   blk_idx,
    output logic               nd_cmd_we,
    output logic               nd_addr_we,
    output logic               nd_rd,
    output logic [7:0]         nd_io,
    input  logic [DATA_W-1:0]  nd_io_in
);
    import nes_pkg::*;

    typedef struct packed {
        state_e             st;
        logic [BLK_W-1:0]   blk;
        logic [BLK_W-1:0]   last;
        logic [PAGE_W-1:0]  page;
        logic [1:0]         sel;
        logic               lp;
        logic [2:0]         cyc;
        logic [SHIFT_W-1:0] shift;
        logic               ok;
        logic               bad;
        logic [BLK_W-1:0]   idx;
        logic               done;
        logic [1:0]         res;
    } seq_t;

    seq_t s_d, s_q;

    logic [2:0] row_n;
    logic [7:0] row_byte;
    logic       tmo_hit;
    logic       st_ready;
    logic       st_fail;
    logic       unused_bits;

    assign st_ready    = nd_io_in[RDY_BIT];
    assign st_fail     = nd_io_in[FAIL_BIT];
    assign unused_bits = ^{nd_io_in[DATA_W-1:7], nd_io_in[5:1]};

    nes_row_fmt #(.PAGE_W(PAGE_W)) u_row (
        .large_page (s_q.lp),
        .addr_cycles(s_q.cyc),
        .page       (s_q.page),
        .sel        (s_q.sel),
        .nbytes     (row_n),
        .row_byte   (row_byte)
    );

    nes_wait_timer #(.DIV_W(DIV_W), .TMO_LIMIT(TMO_LIMIT)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (s_q.st == S_CONF),
        .run    (s_q.st == S_PCMD || s_q.st == S_PRD),
        .div    (tick_div),
        .expired(tmo_hit)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ok   = 1'b0;
        s_d.bad  = 1'b0;
        s_d.done = 1'b0;
        unique case (s_q.st)
            S_IDLE: begin
                if (start) begin
                    if ({1'b0, last_blk} >= blk_count || first_blk > last_blk) begin
                        s_d.done = 1'b1;
                        s_d.res  = RES_RANGE;
                    end else begin
                        s_d.st    = S_SETUP;
                        s_d.blk   = first_blk;
                        s_d.last  = last_blk;
                        s_d.lp    = large_page;
                        s_d.cyc   = addr_cycles;
                        s_d.shift = ppb_shift;
                        s_d.page  = PAGE_W'(first_blk) << ppb_shift;
                    end
                end
            end
            S_SETUP: begin
                s_d.st  = S_ROW;
                s_d.sel = '0;
            end
            S_ROW: begin
                if ({1'b0, s_q.sel} == row_n - 3'd1) s_d.st = S_CONF;
                else                                 s_d.sel = s_q.sel + 1'b1;
            end
            S_CONF: s_d.st = S_PCMD;
            S_PCMD: s_d.st = S_PRD;
            S_PRD: begin
                if (st_ready) begin
                    s_d.st = S_SCMD;
                end else if (tmo_hit) begin
                    s_d.st   = S_IDLE;
                    s_d.done = 1'b1;
                    s_d.res  = RES_TIMEOUT;
                end else begin
                    s_d.st = S_PCMD;
                end
            end
            S_SCMD: s_d.st = S_SRD;
            S_SRD: begin
                s_d.idx = s_q.blk;
                s_d.bad = st_fail;
                s_d.ok  = !st_fail;
                if (s_q.blk == s_q.last) begin
                    s_d.st   = S_IDLE;
                    s_d.done = 1'b1;
                    s_d.res  = RES_OK;
                end else begin
                    s_d.st   = S_SETUP;
                    s_d.blk  = s_q.blk + 1'b1;
                    s_d.page = PAGE_W'(s_d.blk) << s_q.shift;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        nd_cmd_we  = 1'b0;
        nd_addr_we = 1'b0;
        nd_rd      = 1'b0;
        nd_io      = 8'h00;
        case (s_q.st)
            S_SETUP: begin nd_cmd_we = 1'b1; nd_io = OP_ERASE_SETUP; end
            S_ROW:   begin nd_addr_we = 1'b1; nd_io = row_byte; end
            S_CONF:  begin nd_cmd_we = 1'b1; nd_io = OP_ERASE_GO; end
            S_PCMD,
            S_SCMD:  begin nd_cmd_we = 1'b1; nd_io = OP_STATUS; end
            S_PRD,
            S_SRD:   nd_rd = 1'b1;
            default: ;
        endcase
    end

    assign busy    = (s_q.st != S_IDLE);
    assign done    = s_q.done;
    assign result  = s_q.res;
    assign blk_ok  = s_q.ok;
    assign blk_bad = s_q.bad;
    assign blk_idx = s_q.idx;
endmodule

// File: rtl/nes_checker.sv
module nes_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] result,
    input logic       blk_ok,
    input logic       blk_bad,
    input logic       nd_cmd_we,
    input logic       nd_addr_we,
    input logic       nd_rd,
    input logic [7:0] nd_io
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nd_cmd_we, nd_addr_we, nd_rd})); // R3
    AST_SETUP_THEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (nd_cmd_we && nd_io == 8'h60) |=> nd_addr_we); // R3
    AST_CONFIRM_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (nd_cmd_we && nd_io == 8'hD0) |-> $past(nd_addr_we)); // R3
    AST_READ_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        nd_rd |-> $past(nd_cmd_we && nd_io == 8'h70)); // R6
    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_ok && blk_bad)); // R7
    AST_OUTCOME_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_ok || blk_bad) |-> $past(nd_rd)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_RANGE_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd2) |-> $past(!busy)); // R1
endmodule

bind nand_erase_seq nes_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .blk_ok    (blk_ok),
    .blk_bad   (blk_bad),
    .nd_cmd_we (nd_cmd_we),
    .nd_addr_we(nd_addr_we),
    .nd_rd     (nd_rd),
    .nd_io     (nd_io)
);

// File: tb/sim_nand_erase_seq.sv
`timescale 1ns/1ps
module sim_nand_erase_seq;
    localparam int TMO = 6;

    typedef struct packed {
        logic [11:0] first;
        logic [11:0] last;
        logic [12:0] cnt;
        logic        lp;
        logic [2:0]  cyc;
        logic [3:0]  shift;
        logic [3:0]  rdy;
        logic [3:0]  div;
        logic [7:0]  fmask;
        logic [1:0]  res;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{12'd0,     12'd2,     13'd64,   1'b0, 3'd3, 4'd5,  4'd1, 4'd0, 8'h00, 2'd0},
        '{12'd3,     12'd4,     13'd64,   1'b0, 3'd4, 4'd5,  4'd2, 4'd0, 8'h02, 2'd0},
        '{12'h801,   12'h801,   13'd4096, 1'b0, 3'd5, 4'd15, 4'd3, 4'd0, 8'h00, 2'd0},
        '{12'd10,    12'd11,    13'd2048, 1'b1, 3'd4, 4'd6,  4'd2, 4'd0, 8'h01, 2'd0},
        '{12'h3FF,   12'h400,   13'd2048, 1'b1, 3'd5, 4'd6,  4'd1, 4'd0, 8'h03, 2'd0},
        '{12'd5,     12'd8,     13'd8,    1'b0, 3'd3, 4'd5,  4'd1, 4'd0, 8'h00, 2'd2},
        '{12'd6,     12'd5,     13'd64,   1'b0, 3'd3, 4'd5,  4'd1, 4'd0, 8'h00, 2'd2},
        '{12'd7,     12'd7,     13'd8,    1'b0, 3'd3, 4'd4,  4'd1, 4'd0, 8'h00, 2'd0},
        '{12'd2,     12'd3,     13'd64,   1'b0, 3'd3, 4'd5,  4'd0, 4'd0, 8'h00, 2'd1},
        '{12'd2,     12'd3,     13'd64,   1'b0, 3'd3, 4'd5,  4'd0, 4'd1, 8'h00, 2'd1},
        '{12'd1,     12'd1,     13'd64,   1'b0, 3'd4, 4'd5,  4'd7, 4'd1, 8'h00, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] first_blk = '0;
    logic [11:0] last_blk = '0;
    logic [12:0] blk_count = '0;
    logic        large_page = 1'b0;
    logic [2:0]  addr_cycles = '0;
    logic [3:0]  ppb_shift = '0;
    logic [3:0]  tick_div = '0;
    logic        busy, done, blk_ok, blk_bad, nd_cmd_we, nd_addr_we, nd_rd;
    logic [1:0]  result;
    logic [11:0] blk_idx;
    logic [7:0]  nd_io;
    logic [15:0] nd_io_in = 16'h4100;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [8:0] got [256];
    logic [8:0] exp [256];
    int got_n, exp_n;

    always #2.5 clk = ~clk;

    nand_erase_seq #(
        .BLK_W(12), .PAGE_W(32), .SHIFT_W(4), .DIV_W(4), .DATA_W(16), .TMO_LIMIT(TMO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .first_blk(first_blk), .last_blk(last_blk),
        .blk_count(blk_count), .large_page(large_page), .addr_cycles(addr_cycles),
        .ppb_shift(ppb_shift), .tick_div(tick_div), .busy(busy), .done(done), .result(result),
        .blk_ok(blk_ok), .blk_bad(blk_bad), .blk_idx(blk_idx), .nd_cmd_we(nd_cmd_we),
        .nd_addr_we(nd_addr_we), .nd_rd(nd_rd), .nd_io(nd_io), .nd_io_in(nd_io_in)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    function automatic int tmo_polls(input int div);
        for (int j = 1; j < 1000; j++) begin
            if ((2 * j - 1) / (div + 1) >= TMO) return j;
        end
        return 0;
    endfunction

    task automatic push_exp(input logic [8:0] v);
        exp[exp_n] = v;
        exp_n++;
    endtask

    task automatic build_exp(input vec_t v);
        exp_n = 0;
        if (v.res == 2'd2) return;
        for (int b = int'(v.first); b <= int'(v.last); b++) begin
            logic [31:0] page;
            int nb;
            page = 32'(b) << v.shift;
            if (v.lp) nb = (v.cyc >= 5) ? 3 : 2;
            else      nb = (v.cyc >= 5) ? 4 : (v.cyc >= 4) ? 3 : 2;
            push_exp({1'b0, 8'h60});
            for (int k = 0; k < nb; k++) push_exp({1'b1, page[8*k +: 8]});
            push_exp({1'b0, 8'hD0});
            if (v.rdy == 0) begin
                for (int k = 0; k < tmo_polls(int'(v.div)); k++) push_exp({1'b0, 8'h70});
                return;
            end
            for (int k = 0; k < int'(v.rdy) + 1; k++) push_exp({1'b0, 8'h70});
        end
    endtask

    task automatic run_vec(input int n, input vec_t v);
        int polls = 0;
        int d0s = 0;
        int dones = 0;
        logic [1:0] res_seen = 2'd3;
        logic [7:0] okm = '0;
        logic [7:0] badm = '0;
        logic [7:0] rng = '0;
        logic fail_now = 1'b0;
        bit stream_ok;
        got_n = 0;
        build_exp(v);
        @(negedge clk);
        first_blk = v.first; last_blk = v.last; blk_count = v.cnt;
        large_page = v.lp; addr_cycles = v.cyc; ppb_shift = v.shift; tick_div = v.div;
        nd_io_in = 16'h4100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 2000; c++) begin
            if (nd_cmd_we || nd_addr_we) begin
                got[got_n] = {nd_addr_we, nd_io};
                if (got_n < 255) got_n++;
            end
            if (nd_cmd_we && nd_io == 8'hD0) begin
                polls = 0;
                fail_now = v.fmask[d0s[2:0]];
                d0s++;
            end
            if (nd_cmd_we && nd_io == 8'h70) begin
                polls++;
                // R9: high byte carries ready/fail-looking bits that must be ignored
                nd_io_in = {8'h41, 1'b0, (v.rdy != 0 && polls >= int'(v.rdy)), 5'b0, fail_now};
            end
            if (blk_ok)  okm[3'(blk_idx - v.first)] = 1'b1;
            if (blk_bad) badm[3'(blk_idx - v.first)] = 1'b1;
            if (done) begin
                dones++;
                res_seen = result;
            end
            if (dones != 0 && c > 0 && !busy && !done) break;
            @(negedge clk);
        end
        if (v.res == 2'd0) begin
            for (int b = 0; b <= int'(v.last - v.first); b++) rng[b] = 1'b1;
        end
        stream_ok = (got_n == exp_n);
        for (int k = 0; k < exp_n; k++) if (k < got_n && got[k] != exp[k]) stream_ok = 1'b0;
        chk(got_n == exp_n, $sformatf("R3 R4 R5 R6 R8 vec%0d byte count", n), got_n, exp_n);
        chk(stream_ok, $sformatf("R2 R3 R4 R5 vec%0d port sequence", n), stream_ok, 1);
        chk(dones == 1, $sformatf("R10 vec%0d done pulses", n), dones, 1);
        chk(res_seen == v.res, $sformatf("R1 R8 R10 vec%0d result", n), res_seen, v.res);
        chk(okm == (rng & ~v.fmask), $sformatf("R7 vec%0d pass strobes", n), okm, rng & ~v.fmask);
        chk(badm == (rng & v.fmask), $sformatf("R7 R9 vec%0d fail strobes", n), badm, rng & v.fmask);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy && !done && !blk_ok && !blk_bad && !nd_cmd_we && !nd_addr_we && !nd_rd,
            "R10 reset outputs idle", {busy, done, blk_ok, blk_bad, nd_cmd_we, nd_addr_we, nd_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R10 idle after reset release", {busy, done}, 0);

        for (int n = 0; n < NV; n++) run_vec(n, VEC[n]);

        // R10: reset in the middle of polling returns the port to idle
        @(negedge clk);
        first_blk = 12'd0; last_blk = 12'd3; blk_count = 13'd64;
        large_page = 1'b0; addr_cycles = 3'd3; ppb_shift = 4'd5; tick_div = 4'd3;
        nd_io_in = 16'h0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        chk(busy, "R8 still polling before reset", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !nd_cmd_we && !nd_addr_we && !nd_rd,
            "R10 mid-run reset idles port", {busy, done, nd_cmd_we, nd_addr_we, nd_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: range at the block-count boundary after the interrupted run
        run_vec(99, VEC[7]);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule